// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Streaming Converter

The converter accepts a stream of 8-bit-per-channel RGB pixels, one per cycle in which the input valid is high, and turns each into one luma and two colour-difference values. It uses a fixed 3x3 coefficient matrix and per-component offsets. The results leave as a 4:2:2 stream: every pixel carries its own luma, and only every other pixel's chroma is kept. In each pair the first pixel carries Cb and the second carries Cr, and both chroma values come from the first pixel of the pair. A line-start flag travels with the pixel and resets the chroma pairing at the start of each line.

The arithmetic is signed fixed point. The coefficients are scaled by 2^14 and rounded to the nearest integer, and the products come from hardware multipliers. The three products of each component are summed at full precision, rounded by adding half an LSB and shifting right by 14, then offset and clamped to 0..255. The path is split into four register stages so it can run at a high clock rate, and the valid and line-start flags move through those stages in step with the data.

Top module: `csc_rgb_yc422`

## Requirements
- R1: Output luma (out_data[7:0]) equals clamp(0.299·R + 0.587·G + 0.114·B + 16) within 1 LSB.
- R2: On a pixel whose chroma flag is 0, out_data[15:8] equals clamp(-0.169·R - 0.331·G + 0.5·B + 128) within 1 LSB, computed from that pixel.
- R3: On a pixel whose chroma flag is 1, out_data[15:8] equals clamp(0.5·R - 0.419·G - 0.081·B + 128) within 1 LSB, computed from the preceding pixel of the pair.
- R4: Every component is clamped to 0..255: a result above 255, such as white luma or red Cr, comes out as 255.
- R5: An input pixel accepted in cycle n (in_vld high) appears with out_vld high in cycle n+4, and every accepted pixel yields exactly one output.
- R6: out_sol is high on exactly the output of a pixel that entered with in_sol high.
- R7: out_cr_flag is 0 on a line's first pixel and alternates 0,1,0,1 on the valid pixels after it. in_sol restarts the pairing, even after a line of odd length.
- R8: The second pixel of a pair has no effect on the chroma it carries: changing its RGB changes only its luma.
- R9: Cycles with in_vld low produce no output, and the RGB, in_sol and pairing state are not changed by them.
- R10: While reset is active, out_vld and out_sol are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input pixel valid |
| in_sol | input | 1 | First pixel of a line (qualified by in_vld) |
| in_r | input | 8 | Red sample |
| in_g | input | 8 | Green sample |
| in_b | input | 8 | Blue sample |
| out_vld | output | 1 | Output sample valid |
| out_sol | output | 1 | Output sample is the first of a line |
| out_data | output | 16 | Chroma in [15:8], luma in [7:0] |
| out_cr_flag | output | 1 | 0: chroma byte is Cb, 1: chroma byte is Cr |

## Verification
A wrong coefficient, rounding or clamp shows up in the very first output word whose reference value depends on it, four cycles after the pixel enters. The saturated corner colours and the black point each expose the clamp and offset paths directly. A corrupted pairing state shows up as a wrong out_cr_flag on the next valid output, or as a Cr byte that follows the second pixel instead of the first. A stuck or misaligned flag pipeline shows as a missing, extra or early out_vld, or as out_sol on the wrong word. All of these are visible within one pixel pair of the fault.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int COEF_FRAC = 14;
  localparam int COEF_W    = 16;
  localparam int NUM_CH    = 3;

  function automatic int coef_of(int row, int col);
    int k;
    case (row * 3 + col)
      0: k = 4899;
      1: k = 9617;
      2: k = 1868;
      3: k = -2769;
      4: k = -5423;
      5: k = 8192;
      6: k = 8192;
      7: k = -6865;
      default: k = -1327;
    endcase
    return k;
  endfunction

  function automatic int offset_of(int row);
    return (row == 0) ? 16 : 128;
  endfunction

  function automatic int prod_width(int pix_w);
    return pix_w + 1 + COEF_W;
  endfunction

  function automatic int sum_width(int pix_w);
    return prod_width(pix_w) + 2;
  endfunction

  function automatic int res_width(int pix_w);
    return sum_width(pix_w) - COEF_FRAC + 1;
  endfunction
endpackage

// File: rtl/csc_mac.sv
module csc_mac
  import csc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int C0    = 0,
  parameter int C1    = 0,
  parameter int C2    = 0,
  parameter int OFFS  = 0,
  localparam int PROD_W = prod_width(PIX_W),
  localparam int SUM_W  = sum_width(PIX_W),
  localparam int RES_W  = res_width(PIX_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_prod,
  input  logic                    ld_sum,
  input  logic [PIX_W-1:0]        pix_a,
  input  logic [PIX_W-1:0]        pix_b,
  input  logic [PIX_W-1:0]        pix_c,
  output logic signed [RES_W-1:0] res
);
  localparam logic signed [COEF_W-1:0] K0 = COEF_W'(C0);
  localparam logic signed [COEF_W-1:0] K1 = COEF_W'(C1);
  localparam logic signed [COEF_W-1:0] K2 = COEF_W'(C2);
  localparam logic signed [SUM_W-1:0]  HALF = SUM_W'(1) <<< (COEF_FRAC - 1);
  localparam logic signed [RES_W-1:0]  OFFV = RES_W'(OFFS);

  logic signed [PROD_W-1:0] prod_d [3];
  logic signed [PROD_W-1:0] prod_q [3];
  logic signed [SUM_W-1:0]  acc_w;
  logic signed [SUM_W-1:0]  scaled_w;
  logic signed [RES_W-1:0]  res_d;
  logic signed [RES_W-1:0]  res_q;

  always_comb begin
    prod_d = prod_q;
    if (ld_prod) begin
      prod_d[0] = PROD_W'($signed({1'b0, pix_a})) * PROD_W'(K0);
      prod_d[1] = PROD_W'($signed({1'b0, pix_b})) * PROD_W'(K1);
      prod_d[2] = PROD_W'($signed({1'b0, pix_c})) * PROD_W'(K2);
    end
  end

  always_comb begin
    acc_w    = SUM_W'(prod_q[0]) + SUM_W'(prod_q[1]) + SUM_W'(prod_q[2]) + HALF;
    scaled_w = acc_w >>> COEF_FRAC;
    res_d    = ld_sum ? (RES_W'(scaled_w) + OFFV) : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) prod_q[i] <= '0;
      res_q <= '0;
    end else begin
      prod_q <= prod_d;
      res_q  <= res_d;
    end
  end

  assign res = res_q;
endmodule

// File: rtl/csc_decim.sv
module csc_decim #(
  parameter int PIX_W = 8,
  parameter int RES_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s3_vld,
  input  logic                    s3_sol,
  input  logic                    s3_odd,
  input  logic signed [RES_W-1:0] y_raw,
  input  logic signed [RES_W-1:0] cb_raw,
  input  logic signed [RES_W-1:0] cr_raw,
  output logic                    out_vld,
  output logic                    out_sol,
  output logic [2*PIX_W-1:0]      out_data,
  output logic                    out_cr_flag
);
  localparam logic signed [RES_W-1:0] MAXV = RES_W'((1 << PIX_W) - 1);

  function automatic logic [PIX_W-1:0] sat(input logic signed [RES_W-1:0] v);
    if (v < 0)         return '0;
    else if (v > MAXV) return '1;
    else               return v[PIX_W-1:0];
  endfunction

  logic [PIX_W-1:0]   y_c, cb_c, cr_c, chroma_w;
  logic [PIX_W-1:0]   hold_d, hold_q;
  logic [2*PIX_W-1:0] data_d, data_q;
  logic               flag_d, flag_q, vld_d, vld_q, sol_d, sol_q;

  always_comb begin
    y_c      = sat(y_raw);
    cb_c     = sat(cb_raw);
    cr_c     = sat(cr_raw);
    chroma_w = s3_odd ? hold_q : cb_c;
    hold_d   = (s3_vld && !s3_odd) ? cr_c : hold_q;
    data_d   = s3_vld ? {chroma_w, y_c} : data_q;
    flag_d   = s3_vld ? s3_odd : flag_q;
    vld_d    = s3_vld;
    sol_d    = s3_vld & s3_sol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      data_q <= '0;
      flag_q <= 1'b0;
      vld_q  <= 1'b0;
      sol_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      data_q <= data_d;
      flag_q <= flag_d;
      vld_q  <= vld_d;
      sol_q  <= sol_d;
    end
  end

  assign out_vld     = vld_q;
  assign out_sol     = sol_q;
  assign out_data    = data_q;
  assign out_cr_flag = flag_q;

  logic seen_q, last_cr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      last_cr_q <= 1'b0;
    end else if (vld_q) begin
      seen_q    <= 1'b1;
      last_cr_q <= flag_q;
    end
  end

  AST_Y_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_vld && (y_raw > MAXV)) |=> (out_data[PIX_W-1:0] == '1)); // R4
  AST_CB_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_vld && !s3_odd && (cb_raw < 0)) |=> (out_data[2*PIX_W-1:PIX_W] == '0)); // R4
  AST_SOL_IS_CB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_sol) |-> !out_cr_flag); // R7
  AST_CHROMA_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_sol && seen_q) |-> (out_cr_flag != last_cr_q)); // R7
endmodule

// File: rtl/csc_rgb_yc422.sv
module csc_rgb_yc422
  import csc_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int RES_W = res_width(PIX_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_sol,
  input  logic [PIX_W-1:0]   in_r,
  input  logic [PIX_W-1:0]   in_g,
  input  logic [PIX_W-1:0]   in_b,
  output logic               out_vld,
  output logic               out_sol,
  output logic [2*PIX_W-1:0] out_data,
  output logic               out_cr_flag
);
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic             nxt_odd_d, nxt_odd_q;
  logic             s1_vld_d, s1_sol_d, s1_odd_d;
  logic             s1_vld_q, s1_sol_q, s1_odd_q;
  logic [PIX_W-1:0] s1_r_d, s1_g_d, s1_b_d, s1_r_q, s1_g_q, s1_b_q;
  logic             s2_vld_q, s2_sol_q, s2_odd_q;
  logic             s3_vld_q, s3_sol_q, s3_odd_q;

  always_comb begin
    s1_vld_d  = in_vld;
    s1_sol_d  = in_vld & in_sol;
    s1_odd_d  = in_sol ? 1'b0 : nxt_odd_q;
    nxt_odd_d = in_vld ? ~s1_odd_d : nxt_odd_q;
    s1_r_d    = in_vld ? in_r : s1_r_q;
    s1_g_d    = in_vld ? in_g : s1_g_q;
    s1_b_d    = in_vld ? in_b : s1_b_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      nxt_odd_q <= 1'b0;
      s1_vld_q <= 1'b0; s1_sol_q <= 1'b0; s1_odd_q <= 1'b0;
      s1_r_q <= '0; s1_g_q <= '0; s1_b_q <= '0;
      s2_vld_q <= 1'b0; s2_sol_q <= 1'b0; s2_odd_q <= 1'b0;
      s3_vld_q <= 1'b0; s3_sol_q <= 1'b0; s3_odd_q <= 1'b0;
    end else begin
      nxt_odd_q <= nxt_odd_d;
      s1_vld_q <= s1_vld_d;
      s1_sol_q <= s1_sol_d;
      if (in_vld) s1_odd_q <= s1_odd_d;
      s1_r_q <= s1_r_d; s1_g_q <= s1_g_d; s1_b_q <= s1_b_d;
      s2_vld_q <= s1_vld_q; s2_sol_q <= s1_sol_q;
      if (s1_vld_q) s2_odd_q <= s1_odd_q;
      s3_vld_q <= s2_vld_q; s3_sol_q <= s2_sol_q;
      if (s2_vld_q) s3_odd_q <= s2_odd_q;
    end
  end

  logic signed [RES_W-1:0] chan_res [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    csc_mac #(
      .PIX_W(PIX_W),
      .C0(coef_of(ch, 0)),
      .C1(coef_of(ch, 1)),
      .C2(coef_of(ch, 2)),
      .OFFS(offset_of(ch))
    ) u_mac (
      .clk(clk),
      .rst_n(rst_int_n),
      .ld_prod(s1_vld_q),
      .ld_sum(s2_vld_q),
      .pix_a(s1_r_q),
      .pix_b(s1_g_q),
      .pix_c(s1_b_q),
      .res(chan_res[ch])
    );
  end

  csc_decim #(.PIX_W(PIX_W), .RES_W(RES_W)) u_decim (
    .clk(clk),
    .rst_n(rst_int_n),
    .s3_vld(s3_vld_q),
    .s3_sol(s3_sol_q),
    .s3_odd(s3_odd_q),
    .y_raw(chan_res[0]),
    .cb_raw(chan_res[1]),
    .cr_raw(chan_res[2]),
    .out_vld(out_vld),
    .out_sol(out_sol),
    .out_data(out_data),
    .out_cr_flag(out_cr_flag)
  );

  logic [2:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)            since_rst_q <= '0;
    else if (since_rst_q != 4) since_rst_q <= since_rst_q + 3'd1;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (since_rst_q == 4) |-> (out_vld == $past(in_vld, 4))); // R5
  AST_SOL_LATENCY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (since_rst_q == 4) |-> (out_sol == $past(in_vld && in_sol, 4))); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && !out_sol)); // R10
endmodule

// File: tb/csc_rgb_yc422_test.sv
`timescale 1ns/1ps
module csc_rgb_yc422_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, in_sol;
  logic [7:0]  in_r, in_g, in_b;
  logic        out_vld, out_sol, out_cr_flag;
  logic [15:0] out_data;

  always #4 clk = ~clk;

  csc_rgb_yc422 uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sol(in_sol),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_vld(out_vld), .out_sol(out_sol), .out_data(out_data),
    .out_cr_flag(out_cr_flag)
  );

  int  n_run = 0;
  int  n_fail = 0;
  real q_y[$], q_c[$];
  bit  q_cr[$], q_sol[$];
  logic [15:0] cap_d[$];
  bit  cap_f[$], cap_s[$];
  bit  m_odd = 1'b0;
  real m_hold = 128.0;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  function automatic real clip(input real v);
    if (v < 0.0)   return 0.0;
    if (v > 255.0) return 255.0;
    return v;
  endfunction

  function automatic real ref_y(input int r, input int g, input int b);
    return clip(0.299*r + 0.587*g + 0.114*b + 16.0);
  endfunction
  function automatic real ref_cb(input int r, input int g, input int b);
    return clip(-0.169*r - 0.331*g + 0.5*b + 128.0);
  endfunction
  function automatic real ref_cr(input int r, input int g, input int b);
    return clip(0.5*r - 0.419*g - 0.081*b + 128.0);
  endfunction

  function automatic bit near(input real a, input real b);
    return (a - b <= 1.0) && (b - a <= 1.0);
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      cap_d.push_back(out_data);
      cap_f.push_back(out_cr_flag);
      cap_s.push_back(out_sol);
      if (q_y.size() == 0) begin
        check(1'b0, "R9", "output with no accepted pixel", 1.0, 0.0);
      end else begin
        real ey, ec;
        bit  ecr, esol;
        ey = q_y.pop_front(); ec = q_c.pop_front();
        ecr = q_cr.pop_front(); esol = q_sol.pop_front();
        check(near(real'(out_data[7:0]), ey), "R1", "luma", real'(out_data[7:0]), ey);
        if (ecr)
          check(near(real'(out_data[15:8]), ec), "R3", "Cr of pair", real'(out_data[15:8]), ec);
        else
          check(near(real'(out_data[15:8]), ec), "R2", "Cb", real'(out_data[15:8]), ec);
        check(out_cr_flag == ecr, "R7", "chroma flag", real'(out_cr_flag), real'(ecr));
        check(out_sol == esol, "R6", "line start", real'(out_sol), real'(esol));
      end
    end
  end

  task automatic send(input int r, input int g, input int b, input bit sol);
    bit odd;
    @(negedge clk);
    in_vld = 1'b1; in_sol = sol;
    in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    odd = sol ? 1'b0 : m_odd;
    q_y.push_back(ref_y(r, g, b));
    if (!odd) begin
      q_c.push_back(ref_cb(r, g, b));
      m_hold = ref_cr(r, g, b);
    end else begin
      q_c.push_back(m_hold);
    end
    q_cr.push_back(odd);
    q_sol.push_back(sol);
    m_odd = ~odd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_sol = (i % 2) == 0;
      in_r = 8'(i * 91 + 7); in_g = 8'(i * 53); in_b = 8'(255 - i);
    end
  endtask

  task automatic drain();
    idle(10);
    check(q_y.size() == 0, "R5", "pending outputs after drain", real'(q_y.size()), 0.0);
  endtask

  task automatic clear_cap();
    cap_d.delete(); cap_f.delete(); cap_s.delete();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_vld = 1'b0; in_sol = 1'b0;
    in_r = '0; in_g = '0; in_b = '0;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0, "R10", "out_vld in reset", real'(out_vld), 0.0);
    check(out_sol == 1'b0, "R10", "out_sol in reset", real'(out_sol), 0.0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_latency();
    send(10, 200, 30, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1) in_vld = 1'b0;
      if (k < 4) check(out_vld == 1'b0, "R5", "early out_vld", real'(out_vld), 0.0);
      else       check(out_vld == 1'b1, "R5", "out_vld at cycle n+4", real'(out_vld), 1.0);
    end
    drain();
  endtask

  task automatic t_clamp();
    clear_cap();
    send(255, 255, 255, 1'b1);
    send(0, 0, 0, 1'b0);
    send(255, 0, 0, 1'b0);
    send(0, 0, 0, 1'b0);
    send(0, 255, 0, 1'b1);
    send(0, 0, 255, 1'b0);
    send(0, 0, 255, 1'b1);
    send(0, 255, 0, 1'b0);
    drain();
    if (cap_d.size() == 8) begin
      check(cap_d[0][7:0] == 8'd255, "R4", "white luma clamp", real'(cap_d[0][7:0]), 255.0);
      check(cap_d[1][7:0] == 8'd16, "R1", "black luma", real'(cap_d[1][7:0]), 16.0);
      check(cap_d[3][15:8] == 8'd255, "R4", "red Cr clamp", real'(cap_d[3][15:8]), 255.0);
      check(cap_d[6][15:8] == 8'd255, "R4", "blue Cb clamp", real'(cap_d[6][15:8]), 255.0);
    end else begin
      check(1'b0, "R5", "corner output count", real'(cap_d.size()), 8.0);
    end
  endtask

  task automatic t_gradient();
    for (int i = 0; i < 16; i++)
      send((i * 17) % 256, 255 - i * 13, (i * 37) % 256, i == 0);
    drain();
  endtask

  task automatic t_odd_ignored();
    clear_cap();
    send(40, 120, 220, 1'b1);
    send(250, 10, 5, 1'b0);
    send(40, 120, 220, 1'b1);
    send(3, 240, 90, 1'b0);
    drain();
    if (cap_d.size() == 4) begin
      check(cap_d[1][15:8] == cap_d[3][15:8], "R8", "odd chroma follows even",
            real'(cap_d[3][15:8]), real'(cap_d[1][15:8]));
      check(cap_d[1][7:0] != cap_d[3][7:0], "R8", "odd luma still its own",
            real'(cap_d[3][7:0]), real'(cap_d[1][7:0]));
    end else begin
      check(1'b0, "R8", "output count", real'(cap_d.size()), 4.0);
    end
  endtask

  task automatic t_phase_reset();
    clear_cap();
    send(100, 50, 25, 1'b1);
    send(60, 70, 80, 1'b0);
    send(200, 100, 0, 1'b0);
    send(5, 5, 250, 1'b1);
    send(90, 180, 45, 1'b0);
    drain();
    if (cap_f.size() == 5) begin
      check(cap_f[2] == 1'b0 && cap_f[3] == 1'b0 && cap_f[4] == 1'b1, "R7",
            "pairing restarts at line start", real'({cap_f[2], cap_f[3], cap_f[4]}), 1.0);
      check(cap_s[3] == 1'b1, "R6", "second line flagged", real'(cap_s[3]), 1.0);
    end else begin
      check(1'b0, "R7", "output count", real'(cap_f.size()), 5.0);
    end
  endtask

  task automatic t_bubbles();
    clear_cap();
    send(30, 60, 90, 1'b1);
    idle(2);
    send(120, 130, 140, 1'b0);
    idle(1);
    send(210, 20, 70, 1'b0);
    idle(3);
    send(15, 25, 35, 1'b0);
    drain();
    check(cap_d.size() == 4, "R9", "one output per accepted pixel", real'(cap_d.size()), 4.0);
    if (cap_f.size() == 4)
      check(cap_f[0] == 0 && cap_f[1] == 1 && cap_f[2] == 0 && cap_f[3] == 1, "R9",
            "bubbles keep pairing", real'({cap_f[0], cap_f[1], cap_f[2], cap_f[3]}), 5.0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_clamp();
    t_gradient();
    t_odd_ignored();
    t_phase_reset();
    t_bubbles();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule